// File: doc/BRIEF.md
# Coprocessor Mailbox and Address Decoder

This block is the glue logic on the coprocessor side of a plug-in cartridge that carries its own 8-bit CPU. It splits the coprocessor's 16-bit address space into three regions: battery-backed work RAM at the bottom, program ROM in the upper half, and a small mailbox window just below the ROM. The RAM and ROM arrays sit outside the block. Only their select lines are produced here.

Two one-byte latches let the host and the coprocessor exchange bytes. One carries bytes from the host to the coprocessor and the other carries bytes the other way. Each latch is a two-state machine with the states `SLOT_EMPTY` and `SLOT_FULL`:

- The `PUT` transition (EMPTY to FULL) happens when the sender writes.
- The `OVERWRITE` transition (FULL to FULL) happens when the sender writes again before the byte has been read.
- The `TAKE` transition (FULL to EMPTY) happens when the receiver reads and there is no write in the same cycle.

While a latch is FULL, it holds a registered, active-high NMI toward its receiver.

The host side uses a plain write strobe with data and a read strobe. The coprocessor side uses its address bus, its data buses and its read and write strobes.

Top module: `cart_mailbox_glue`

## Requirements
- R1: `ram_sel` is high exactly when address bits 15, 14 and 13 are all zero (0x0000–0x1FFF).
- R2: `rom_sel` is high exactly when address bit 15 is one (0x8000–0xFFFF). This holds even when bits 14..8 are all ones.
- R3: The mailbox window covers 0x7F00–0x7FFF. Bit 15 must be zero and bits 14..8 must be ones. Bits 7..0 are ignored. At most one of RAM, ROM and window is selected, and other addresses (for example 0x2000 or 0x7EFF) select nothing.
- R4: `cp_rdata` shows the host-to-coprocessor byte whenever the address is in the window, and shows 0xFF at every other address.
- R5: A coprocessor write inside the window loads the coprocessor-to-host byte, which appears on `host_rdata` one cycle later. A coprocessor write outside the window leaves that byte unchanged.
- R6: A host write loads the host-to-coprocessor byte and takes that latch to FULL. `cp_nmi` is high from the cycle after the write.
- R7: A coprocessor read inside the window takes the host-to-coprocessor latch to EMPTY. `cp_nmi` is low from the next cycle.
- R8: A coprocessor write inside the window raises `host_nmi` from the next cycle. A host read lowers `host_nmi` from the next cycle.
- R9: When a latch is written and read in the same cycle, the write wins: the new byte is stored and the NMI stays high.
- R10: Reset clears both NMI outputs, returns both latches to EMPTY and sets both bytes to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cp_addr | input | 16 | Coprocessor address bus |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_rd | input | 1 | Coprocessor read strobe, one cycle per access |
| cp_wr | input | 1 | Coprocessor write strobe, one cycle per access |
| cp_rdata | output | 8 | Read data from the mailbox window, 0xFF elsewhere |
| ram_sel | output | 1 | Work RAM select |
| rom_sel | output | 1 | Program ROM select |
| host_wr | input | 1 | Host write strobe for the host-to-coprocessor byte |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe, acknowledges the coprocessor-to-host byte |
| host_rdata | output | 8 | Coprocessor-to-host byte |
| cp_nmi | output | 1 | NMI to the coprocessor, high while a host byte is unread |
| host_nmi | output | 1 | NMI to the host, high while a coprocessor byte is unread |

## Verification
The assertions assume that each strobe is high for exactly one cycle per access. They also assume that `cp_rd` and `cp_wr` are never high together, since a single-bus CPU cannot read and write in the same cycle. The stimulus drives each strobe for one clock and never raises both coprocessor strobes at once. The stimulus does combine a sender's write with the receiver's read in one cycle, which is the allowed collision covered by R9.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_BITS = 8,
    parameter int RAM_BITS  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_sel,
    output logic              port_sel,
    output logic              rom_sel
);
    localparam int TOP = ADDR_W - 1;

    logic unused_page_offset;
    assign unused_page_offset = ^addr[PAGE_BITS-1:0];

    always_comb begin
        ram_sel  = (addr[TOP -: RAM_BITS] == '0);
        rom_sel  = addr[TOP];
        port_sel = !addr[TOP] && (&addr[TOP-1:PAGE_BITS]);
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    output logic [DATA_W-1:0] rdata,
    output logic              pending
);
    slot_state_e state_q, state_d;
    logic [DATA_W-1:0] byte_q;

    // State register: PUT and OVERWRITE on load, TAKE on a read without a load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_EMPTY;
            byte_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load) byte_q <= wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (load) state_d = SLOT_FULL;
            SLOT_FULL:  if (take && !load) state_d = SLOT_EMPTY;
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // Outputs come straight from registers, so the NMI level cannot glitch
    always_comb begin
        pending = (state_q == SLOT_FULL);
        rdata   = byte_q;
    end
endmodule

// File: rtl/cart_mailbox_glue.sv
module cart_mailbox_glue #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [DATA_W-1:0] cp_wdata,
    input  logic              cp_rd,
    input  logic              cp_wr,
    output logic [DATA_W-1:0] cp_rdata,
    output logic              ram_sel,
    output logic              rom_sel,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cp_nmi,
    output logic              host_nmi
);
    logic              port_sel;
    logic [DATA_W-1:0] h2c_byte;

    mbx_decode #(.ADDR_W(ADDR_W)) decode_i (
        .addr    (cp_addr),
        .ram_sel (ram_sel),
        .port_sel(port_sel),
        .rom_sel (rom_sel)
    );

    // Host to coprocessor: the host writes, a coprocessor read of the window acknowledges
    mbx_slot #(.DATA_W(DATA_W)) h2c_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (host_wr),
        .wdata  (host_wdata),
        .take   (cp_rd && port_sel),
        .rdata  (h2c_byte),
        .pending(cp_nmi)
    );

    // Coprocessor to host: a coprocessor write to the window loads, a host read acknowledges
    mbx_slot #(.DATA_W(DATA_W)) c2h_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cp_wr && port_sel),
        .wdata  (cp_wdata),
        .take   (host_rd),
        .rdata  (host_rdata),
        .pending(host_nmi)
    );

    always_comb begin
        cp_rdata = port_sel ? h2c_byte : '1;
    end
endmodule

// File: rtl/cart_mailbox_glue_chk.sv
module cart_mailbox_glue_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cp_addr,
    input logic [DATA_W-1:0] cp_wdata,
    input logic              cp_rd,
    input logic              cp_wr,
    input logic [DATA_W-1:0] cp_rdata,
    input logic              ram_sel,
    input logic              rom_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_rdata,
    input logic              cp_nmi,
    input logic              host_nmi
);
    logic win;
    assign win = (cp_addr[ADDR_W-1:8] == {1'b0, {(ADDR_W-9){1'b1}}});

    assert_region_mutex_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_sel, rom_sel, win}));
    assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !win |-> cp_rdata == '1);
    assert_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr && win) |=> host_rdata == $past(cp_wdata));
    assert_cp_nmi_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> cp_nmi);
    assert_cp_nmi_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_rd && win && !host_wr) |=> !cp_nmi);
    assert_host_nmi_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr && win) |=> host_nmi);
    assert_host_nmi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !(cp_wr && win)) |=> !host_nmi);
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cp_nmi && !host_wr) |=> !cp_nmi);
endmodule

bind cart_mailbox_glue cart_mailbox_glue_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
    .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_rdata(cp_rdata), .ram_sel(ram_sel),
    .rom_sel(rom_sel), .host_wr(host_wr), .host_rd(host_rd),
    .host_rdata(host_rdata), .cp_nmi(cp_nmi), .host_nmi(host_nmi)
);

// File: tb/cart_mailbox_glue_tb.sv
module cart_mailbox_glue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cp_addr = 16'h0000;
    logic [7:0]  cp_wdata = 8'h00;
    logic        cp_rd = 1'b0, cp_wr = 1'b0;
    logic [7:0]  cp_rdata;
    logic        ram_sel, rom_sel;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        cp_nmi, host_nmi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cart_mailbox_glue dut_i (
        .clk(clk), .rst_n(rst_n), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_rd(cp_rd), .cp_wr(cp_wr), .cp_rdata(cp_rdata), .ram_sel(ram_sel),
        .rom_sel(rom_sel), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_rdata(host_rdata), .cp_nmi(cp_nmi),
        .host_nmi(host_nmi)
    );

    // Each entry packs {address, expect ram_sel, expect rom_sel, expect window}
    localparam logic [18:0] VEC [12] = '{
        {16'h0000, 3'b100}, {16'h1FFF, 3'b100}, {16'h2000, 3'b000},
        {16'h6000, 3'b000}, {16'h3F00, 3'b000}, {16'h7EFF, 3'b000},
        {16'h7F00, 3'b001}, {16'h7F80, 3'b001}, {16'h7FFF, 3'b001},
        {16'h8000, 3'b010}, {16'hFF00, 3'b010}, {16'hFFFF, 3'b010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        step();
        cp_addr = 16'h7F00;
        #1;
        // R10: reset state
        check("R10 cp_nmi", cp_nmi, 0);
        check("R10 host_nmi", host_nmi, 0);
        check("R10 host_rdata", host_rdata, 8'h00);
        check("R10 cp_rdata", cp_rdata, 8'h00);
        rst_n = 1'b1;
        step();

        // R6: host write raises cp_nmi and stores the byte
        host_wr = 1'b1; host_wdata = 8'hA5;
        step();
        host_wr = 1'b0;
        check("R6 cp_nmi", cp_nmi, 1);

        // R1 R2 R3 R4: decode table, read strobe idle so nothing is acknowledged
        foreach (VEC[i]) begin
            cp_addr = VEC[i][18:3];
            #1;
            check("R1 ram_sel", ram_sel, VEC[i][2]);
            check("R2 rom_sel", rom_sel, VEC[i][1]);
            check("R4 cp_rdata", cp_rdata, VEC[i][0] ? 8'hA5 : 8'hFF);
        end
        step();
        check("R3 no ack from decode walk", cp_nmi, 1);

        // R7: coprocessor read of a mirrored window address clears cp_nmi
        cp_addr = 16'h7F42; cp_rd = 1'b1;
        step();
        cp_rd = 1'b0;
        check("R7 cp_nmi", cp_nmi, 0);

        // R5 R8: coprocessor write in the window
        cp_addr = 16'h7FC3; cp_wdata = 8'h3C; cp_wr = 1'b1;
        step();
        cp_wr = 1'b0;
        check("R8 host_nmi set", host_nmi, 1);
        check("R5 host_rdata", host_rdata, 8'h3C);

        // R5: write just below the window has no effect
        cp_addr = 16'h7EFF; cp_wdata = 8'h99; cp_wr = 1'b1;
        step();
        cp_wr = 1'b0;
        check("R5 outside write ignored", host_rdata, 8'h3C);

        // R8: host read clears host_nmi
        host_rd = 1'b1;
        step();
        host_rd = 1'b0;
        check("R8 host_nmi clear", host_nmi, 0);

        // R9: host write and coprocessor read in the same cycle
        host_wr = 1'b1; host_wdata = 8'h77; cp_addr = 16'h7F10; cp_rd = 1'b1;
        step();
        host_wr = 1'b0; host_wdata = 8'h77; cp_rd = 1'b0;
        check("R9 cp_nmi held", cp_nmi, 1);
        check("R9 new byte", cp_rdata, 8'h77);

        // R9: coprocessor write and host read in the same cycle
        cp_addr = 16'h7F01; cp_wdata = 8'hC8; cp_wr = 1'b1; host_rd = 1'b1;
        step();
        cp_wr = 1'b0; host_rd = 1'b0;
        check("R9 host_nmi held", host_nmi, 1);
        check("R9 host byte", host_rdata, 8'hC8);

        // R10: reset mid-run clears both sides
        rst_n = 1'b0;
        #1;
        check("R10 cp_nmi after reset", cp_nmi, 0);
        check("R10 host_nmi after reset", host_nmi, 0);
        check("R10 host byte after reset", host_rdata, 8'h00);
        cp_addr = 16'h7F00;
        #1;
        check("R10 cp byte after reset", cp_rdata, 8'h00);
        step();
        rst_n = 1'b1;
        step();

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule